// File: doc/BRIEF.md
# Paged Dual-Channel Waveform Capture Buffer

This block records fixed-length waveforms from a two-channel converter and keeps them in on-chip memory until a host collects them. Each channel arrives as two 12-bit streams sampled on both edges of the capture clock, so every capture-clock cycle carries four new samples per channel. After an arm request, a trigger starts a capture. The capture fills one page of a ring of pages, and each page holds one complete two-channel waveform.

The host side runs on its own clock. It sees the pages as a queue. It reads any word of the oldest complete page by its sample index, and each 32-bit word carries the same-index sample of both channels. A page-advance pulse releases the oldest page so the capture side can reuse it. The count of filled pages crosses between the clock domains as Gray-coded pointers. A capture-busy flag and a sticky overflow flag are also brought to the host clock.

Top module: `wcap_buffer`

## Requirements
- R1: Within a cycle, sample index 4n comes from stream 0 on the rising edge and 4n+1 from stream 1 on the rising edge. Index 4n+2 comes from stream 0 on the falling edge and 4n+3 from stream 1 on the falling edge. The same mapping holds for both channels.
- R2: An accepted capture stores 2**SAMPLES_LOG2 samples per channel over 2**SAMPLES_LOG2/4 capture cycles. Sample 0 is the stream-0 value taken at the rising edge that samples the trigger.
- R3: A read word holds channel A in bits 11:0 and channel B in bits 27:16. Bits 15:12 and 31:28 are zero.
- R4: A trigger with no prior arm is ignored. An accepted trigger consumes the arm, so a later trigger without a new arm starts nothing.
- R5: `host_filled` reports 0 to PAGES filled pages. It rises by one after each capture completes and falls by one on each accepted page advance.
- R6: A page advance while no page is filled is ignored and leaves the count and the read page unchanged.
- R7: A trigger while armed and all PAGES pages are filled is dropped. It writes nothing, keeps the arm, and sets `host_ovf`, which stays set until reset.
- R8: Pages are read in capture order. Reads show the oldest filled page, and an advance moves the view to the next one.
- R9: A read while no page is filled returns zero and changes no state.
- R10: Read data appears on `host_rdata` after the first host-clock rising edge at which `host_rd` is sampled high.
- R11: `host_busy` is high, after synchronization, while a capture is in progress and low otherwise.
- R12: Page slots are reused in ring order after wrap-around, and captures after the wrap read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock; data taken on both edges |
| cap_rst_n | input | 1 | Active-low reset, capture domain |
| ch_a_s0 | input | 12 | Channel A stream 0 (lower index of each edge pair) |
| ch_a_s1 | input | 12 | Channel A stream 1 |
| ch_b_s0 | input | 12 | Channel B stream 0 |
| ch_b_s1 | input | 12 | Channel B stream 1 |
| cap_arm | input | 1 | Arm request, one capture-clock pulse |
| cap_trig | input | 1 | Trigger, sampled on the capture-clock rising edge |
| host_clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Active-low reset, host domain |
| host_rd | input | 1 | Read strobe |
| host_addr | input | SAMPLES_LOG2 | Sample index within the oldest page |
| host_rdata | output | 32 | Packed read word |
| host_adv | input | 1 | Page-advance pulse |
| host_filled | output | $clog2(PAGES+1) | Number of filled pages |
| host_busy | output | 1 | Capture in progress (synchronized) |
| host_ovf | output | 1 | Sticky overflow (synchronized) |

## Verification
A wrong slot, row or bank index corrupts whole pages. It shows up as mismatched words at the very first read of the affected page, because every word of every page is compared against an arithmetic sample pattern. A wrong pointer or page count shows up within a few host cycles after a capture or advance, as a wrong `host_filled`, a nonzero read from an empty buffer, or a dropped trigger that overwrites the oldest page. That page is read right after the overflow attempt. A broken edge or stream ordering swaps neighbouring samples and is caught at index 0 to 3 of the first page.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int SMP_W = 12;

  typedef logic [SMP_W-1:0] smp_t;

  typedef struct packed {
    smp_t a;
    smp_t b;
  } pair_t;

  // Channel A in the low half-word, channel B in the high half-word.
  function automatic logic [31:0] pack_word(input pair_t p);
    return {4'h0, p.b, 4'h0, p.a};
  endfunction

  // Pointer codecs, sized for pointers up to 8 bits wide.
  function automatic logic [7:0] gray_enc(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] gray_dec(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/wcap_ddr_merge.sv
module wcap_ddr_merge
  import wcap_pkg::*;
(
  input  logic           clk,
  input  smp_t           a_s0,
  input  smp_t           a_s1,
  input  smp_t           b_s0,
  input  smp_t           b_s1,
  output pair_t [3:0]    grp
);
  smp_t ra0, ra1, rb0, rb1;
  smp_t fa0, fa1, fb0, fb1;

  always_ff @(posedge clk) begin
    ra0 <= a_s0;
    ra1 <= a_s1;
    rb0 <= b_s0;
    rb1 <= b_s1;
  end

  always_ff @(negedge clk) begin
    fa0 <= a_s0;
    fa1 <= a_s1;
    fb0 <= b_s0;
    fb1 <= b_s1;
  end

  // R1: index order rising s0, rising s1, falling s0, falling s1
  always_comb begin
    grp[0] = '{a: ra0, b: rb0};
    grp[1] = '{a: ra1, b: rb1};
    grp[2] = '{a: fa0, b: fb0};
    grp[3] = '{a: fa1, b: fb1};
  end
endmodule

// File: rtl/wcap_bank.sv
module wcap_bank
  import wcap_pkg::*;
#(
  parameter int DEPTH = 768,
  parameter int AW    = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pair_t         wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output pair_t         rdata
);
  pair_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wcap_gray_sync.sv
module wcap_gray_sync
  import wcap_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] g_in,
  output logic [W-1:0] b_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= g_in;
      s2 <= s1;
    end
  end

  assign b_out = W'(gray_dec(8'(s2)));

  // R5: the synchronized pointer moves by at most one code step per cycle
  a_r5_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s2 ^ $past(s2)) <= 1);
endmodule

// File: rtl/wcap_capture_ctl.sv
module wcap_capture_ctl
  import wcap_pkg::*;
#(
  parameter int PAGES = 12,
  parameter int ROWS  = 64,
  parameter int PW    = 5,
  parameter int RAW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  input  logic [PW-1:0] rd_ptr_sync,
  output logic          we,
  output logic [RAW-1:0] wrow,
  output logic [PW-1:0] wr_gray,
  output logic          busy,
  output logic          ovf
);
  localparam int CNW = $clog2(ROWS);
  localparam int SLW = $clog2(PAGES);

  logic           armed;
  logic [CNW-1:0] cnt;
  logic [SLW-1:0] slot;
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  fill;
  logic           full;
  logic           start_ev, drop_ev, done_ev;

  function automatic logic [RAW-1:0] row_of(input logic [SLW-1:0] s,
                                            input logic [CNW-1:0] c);
    return RAW'(s) * RAW'(ROWS) + RAW'(c);
  endfunction

  assign fill     = wr_ptr - rd_ptr_sync;
  assign full     = (fill >= PW'(PAGES));
  assign start_ev = trig & armed & ~busy & ~full;
  assign drop_ev  = trig & armed & ~busy & full;
  assign done_ev  = busy & (cnt == CNW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      busy    <= 1'b0;
      ovf     <= 1'b0;
      cnt     <= '0;
      slot    <= '0;
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else begin
      armed <= (armed | arm) & ~start_ev;
      if (drop_ev) ovf <= 1'b1;
      if (start_ev) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (done_ev) begin
          busy   <= 1'b0;
          wr_ptr <= wr_ptr + 1'b1;
          slot   <= (slot == SLW'(PAGES - 1)) ? '0 : slot + 1'b1;
        end
      end
      wr_gray <= PW'(gray_enc(8'(wr_ptr)));
    end
  end

  assign we   = busy;
  assign wrow = row_of(slot, cnt);

  // R4: an accepted trigger opens a capture at row 0
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (busy && cnt == '0));
  // R7: a dropped trigger opens no capture
  a_r7_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> !busy);
  // R7: overflow is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R5: capture side never sees more than PAGES filled pages
  a_r5_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(PAGES));
endmodule

// File: rtl/wcap_host_ctl.sv
module wcap_host_ctl
  import wcap_pkg::*;
#(
  parameter int PAGES = 12,
  parameter int ROWS  = 64,
  parameter int PW    = 5,
  parameter int RAW   = 10,
  parameter int AW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic           adv,
  input  logic [PW-1:0]  wr_ptr_sync,
  output logic           re,
  output logic [RAW-1:0] rrow,
  output logic [1:0]     sel_q,
  output logic           empty_q,
  output logic [PW-1:0]  rd_gray,
  output logic [PW-1:0]  fill
);
  localparam int SLW = $clog2(PAGES);

  logic [PW-1:0]  rd_ptr;
  logic [SLW-1:0] slot;
  logic           empty;
  logic           adv_ev;

  function automatic logic [RAW-1:0] row_of(input logic [SLW-1:0] s,
                                            input logic [AW-3:0] r);
    return RAW'(s) * RAW'(ROWS) + RAW'(r);
  endfunction

  assign fill   = wr_ptr_sync - rd_ptr;
  assign empty  = (fill == '0);
  assign adv_ev = adv & ~empty;
  assign re     = rd_en;
  assign rrow   = row_of(slot, addr[AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      slot    <= '0;
      sel_q   <= '0;
      empty_q <= 1'b1;
      rd_gray <= '0;
    end else begin
      if (rd_en) begin
        sel_q   <= addr[1:0];
        empty_q <= empty;
      end
      if (adv_ev) begin
        rd_ptr <= rd_ptr + 1'b1;
        slot   <= (slot == SLW'(PAGES - 1)) ? '0 : slot + 1'b1;
      end
      rd_gray <= PW'(gray_enc(8'(rd_ptr)));
    end
  end

  // R6: advance on an empty buffer leaves the read pointer alone
  a_r6_adv_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && empty) |=> $stable(rd_ptr));
  // R5: host count stays within 0..PAGES
  a_r5_host_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(PAGES));
endmodule

// File: rtl/wcap_buffer.sv
module wcap_buffer
  import wcap_pkg::*;
#(
  parameter int PAGES        = 12,
  parameter int SAMPLES_LOG2 = 8
) (
  input  logic                       cap_clk,
  input  logic                       cap_rst_n,
  input  logic [11:0]                ch_a_s0,
  input  logic [11:0]                ch_a_s1,
  input  logic [11:0]                ch_b_s0,
  input  logic [11:0]                ch_b_s1,
  input  logic                       cap_arm,
  input  logic                       cap_trig,
  input  logic                       host_clk,
  input  logic                       host_rst_n,
  input  logic                       host_rd,
  input  logic [SAMPLES_LOG2-1:0]    host_addr,
  output logic [31:0]                host_rdata,
  input  logic                       host_adv,
  output logic [$clog2(PAGES+1)-1:0] host_filled,
  output logic                       host_busy,
  output logic                       host_ovf
);
  localparam int ROWS  = 2 ** (SAMPLES_LOG2 - 2);
  localparam int DEPTH = PAGES * ROWS;
  localparam int RAW   = $clog2(DEPTH);
  localparam int PW    = $clog2(PAGES) + 1;
  localparam int CW    = $clog2(PAGES + 1);

  pair_t [3:0]    grp;
  pair_t          bank_q [4];
  logic           we;
  logic [RAW-1:0] wrow, rrow;
  logic [PW-1:0]  wr_gray, rd_gray, wr_sync, rd_sync, fill;
  logic           cap_busy, cap_ovf;
  logic           re, empty_q;
  logic [1:0]     sel_q;
  logic [1:0]     busy_s, ovf_s;

  wcap_ddr_merge u_merge (
    .clk (cap_clk),
    .a_s0(ch_a_s0), .a_s1(ch_a_s1),
    .b_s0(ch_b_s0), .b_s1(ch_b_s1),
    .grp (grp)
  );

  wcap_capture_ctl #(.PAGES(PAGES), .ROWS(ROWS), .PW(PW), .RAW(RAW)) u_cap (
    .clk        (cap_clk),
    .rst_n      (cap_rst_n),
    .arm        (cap_arm),
    .trig       (cap_trig),
    .rd_ptr_sync(rd_sync),
    .we         (we),
    .wrow       (wrow),
    .wr_gray    (wr_gray),
    .busy       (cap_busy),
    .ovf        (cap_ovf)
  );

  // One bank per sample position within a four-sample group.
  for (genvar i = 0; i < 4; i++) begin : g_bank
    wcap_bank #(.DEPTH(DEPTH), .AW(RAW)) u_bank (
      .wclk (cap_clk),
      .we   (we),
      .waddr(wrow),
      .wdata(grp[i]),
      .rclk (host_clk),
      .re   (re),
      .raddr(rrow),
      .rdata(bank_q[i])
    );
  end

  wcap_gray_sync #(.W(PW)) u_wsync (
    .clk(host_clk), .rst_n(host_rst_n), .g_in(wr_gray), .b_out(wr_sync)
  );

  wcap_gray_sync #(.W(PW)) u_rsync (
    .clk(cap_clk), .rst_n(cap_rst_n), .g_in(rd_gray), .b_out(rd_sync)
  );

  wcap_host_ctl #(.PAGES(PAGES), .ROWS(ROWS), .PW(PW), .RAW(RAW),
                  .AW(SAMPLES_LOG2)) u_host (
    .clk        (host_clk),
    .rst_n      (host_rst_n),
    .rd_en      (host_rd),
    .addr       (host_addr),
    .adv        (host_adv),
    .wr_ptr_sync(wr_sync),
    .re         (re),
    .rrow       (rrow),
    .sel_q      (sel_q),
    .empty_q    (empty_q),
    .rd_gray    (rd_gray),
    .fill       (fill)
  );

  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) begin
      busy_s <= '0;
      ovf_s  <= '0;
    end else begin
      busy_s <= {busy_s[0], cap_busy};
      ovf_s  <= {ovf_s[0], cap_ovf};
    end
  end

  assign host_busy   = busy_s[1];
  assign host_ovf    = ovf_s[1];
  assign host_filled = fill[CW-1:0];
  assign host_rdata  = empty_q ? 32'h0 : pack_word(bank_q[sel_q]);

  // R9: an empty read yields an all-zero word
  a_r9_empty_zero: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    empty_q |-> (host_rdata == 32'h0));
endmodule

// File: tb/sim_wcap_buffer.sv
module sim_wcap_buffer;
  localparam int PAGES = 12;
  localparam int SL2   = 8;
  localparam int NS    = 2 ** SL2;
  localparam int GRPS  = NS / 4;

  logic        cap_clk = 0, host_clk = 0;
  logic        cap_rst_n = 0, host_rst_n = 0;
  logic [11:0] a0 = 0, a1 = 0, b0 = 0, b1 = 0;
  logic        arm = 0, trig = 0;
  logic        hrd = 0, hadv = 0;
  logic [SL2-1:0] haddr = 0;
  logic [31:0] hdata;
  logic [3:0]  hfilled;
  logic        hbusy, hovf;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 cap_clk = ~cap_clk;
  always #5 host_clk = ~host_clk;

  wcap_buffer #(.PAGES(PAGES), .SAMPLES_LOG2(SL2)) u0 (
    .cap_clk(cap_clk), .cap_rst_n(cap_rst_n),
    .ch_a_s0(a0), .ch_a_s1(a1), .ch_b_s0(b0), .ch_b_s1(b1),
    .cap_arm(arm), .cap_trig(trig),
    .host_clk(host_clk), .host_rst_n(host_rst_n),
    .host_rd(hrd), .host_addr(haddr), .host_rdata(hdata),
    .host_adv(hadv), .host_filled(hfilled),
    .host_busy(hbusy), .host_ovf(hovf)
  );

  function automatic logic [11:0] smp(input int tag, input int idx, input int ch);
    return 12'((tag * 131) + (idx * 7) + (ch * 2011) + ((idx / 4) * 3));
  endfunction

  function automatic logic [31:0] exp_word(input int tag, input int idx);
    return {4'h0, smp(tag, idx, 1), 4'h0, smp(tag, idx, 0)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwait(input int n);
    repeat (n) @(negedge host_clk);
  endtask

  task automatic do_arm();
    @(negedge cap_clk); #1 arm = 1;
    @(posedge cap_clk); #1 arm = 0;
  endtask

  // Drives one full capture's data; trigger rides with group 0 rising data.
  task automatic do_capture(input int tag, input bit pulse_trig, output bit busy_seen);
    busy_seen = 0;
    for (int g = 0; g < GRPS; g++) begin
      @(negedge cap_clk); #1;
      a0 = smp(tag, 4*g, 0);   a1 = smp(tag, 4*g+1, 0);
      b0 = smp(tag, 4*g, 1);   b1 = smp(tag, 4*g+1, 1);
      trig = (g == 0) && pulse_trig;
      @(posedge cap_clk); #1;
      trig = 0;
      a0 = smp(tag, 4*g+2, 0); a1 = smp(tag, 4*g+3, 0);
      b0 = smp(tag, 4*g+2, 1); b1 = smp(tag, 4*g+3, 1);
      if (g == GRPS/2) busy_seen = hbusy;
    end
    @(posedge cap_clk); #1;
  endtask

  task automatic hread(input int a, output logic [31:0] d);
    @(negedge host_clk); hrd = 1; haddr = SL2'(a);
    @(negedge host_clk); hrd = 0; d = hdata;
  endtask

  task automatic hadvance();
    @(negedge host_clk); hadv = 1;
    @(negedge host_clk); hadv = 0;
  endtask

  task automatic read_page(input int tag, input string req);
    logic [31:0] d;
    for (int i = 0; i < NS; i++) begin
      hread(i, d);
      check(req, d, exp_word(tag, i));
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit bs;
    int model_fill;

    #23; cap_rst_n = 1; host_rst_n = 1;
    hwait(3);
    // Reset state
    check("R5 reset filled", 32'(hfilled), 0);
    check("R11 reset busy", 32'(hbusy), 0);
    check("R7 reset ovf", 32'(hovf), 0);
    check("R9 reset rdata", hdata, 0);

    // Empty read and empty advance
    hread(5, d);
    check("R9 empty read", d, 0);
    hadvance();
    hwait(2);
    check("R6 adv on empty", 32'(hfilled), 0);

    // Trigger without arm
    do_capture(77, 1, bs);
    hwait(10);
    check("R4 trig without arm", 32'(hfilled), 0);
    check("R11 no capture no busy", 32'(bs), 0);

    // First real capture
    do_arm();
    do_capture(1, 1, bs);
    hwait(10);
    check("R11 busy during capture", 32'(bs), 1);
    check("R11 busy after capture", 32'(hbusy), 0);
    check("R5 filled after capture", 32'(hfilled), 1);

    // Arm consumed
    do_capture(78, 1, bs);
    hwait(10);
    check("R4 arm consumed", 32'(hfilled), 1);

    // Full page sweep: ordering, packing, length, latency
    read_page(1, "R1 R2 R3 R10 page tag1");
    check("R9 R8 read keeps page", 32'(hfilled), 1);

    // Fill remaining pages
    model_fill = 1;
    for (int t = 2; t <= PAGES; t++) begin
      do_arm();
      do_capture(t, 1, bs);
      hwait(10);
      model_fill++;
      check("R5 filling", 32'(hfilled), 32'(model_fill));
    end

    // Overflow attempt
    check("R7 ovf clear before full trig", 32'(hovf), 0);
    do_arm();
    do_capture(99, 1, bs);
    hwait(10);
    check("R7 ovf set", 32'(hovf), 1);
    check("R7 filled stays full", 32'(hfilled), PAGES);
    check("R7 drop no busy", 32'(bs), 0);

    // Drain in FIFO order, all words
    for (int p = 1; p <= PAGES; p++) begin
      read_page(p, "R8 R7 FIFO page");
      hadvance();
      hwait(1);
      model_fill--;
      check("R5 after advance", 32'(hfilled), 32'(model_fill));
    end
    hread(3, d);
    check("R9 read after drain", d, 0);
    hadvance();
    hwait(2);
    check("R6 adv after drain", 32'(hfilled), 0);
    check("R7 ovf sticky", 32'(hovf), 1);

    // Wrap-around reuse
    hwait(5);
    do_arm();
    do_capture(13, 1, bs);
    do_arm();
    do_capture(14, 1, bs);
    hwait(10);
    check("R12 filled after wrap", 32'(hfilled), 2);
    read_page(13, "R12 wrapped page 13");
    hadvance();
    read_page(14, "R12 wrapped page 14");
    hadvance();
    hwait(2);
    check("R12 drained", 32'(hfilled), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule